// File: doc/BRIEF.md
# Line-Synchronised DMA Table Loader

This block holds the table-walking part of one channel of a DMA engine that moves a little data on every display line. The channel keeps a line counter. At each line event, when the low seven bits of that counter are not zero, the counter steps down by one. When those bits are zero, the loader starts a fetch sequence. It reads the next count byte from a table in memory, at the address formed by the bank input above the table pointer. In indirect mode it then reads one or two more table bytes, which make up the address the transfer phase will use.

Every table read occupies an eight-clock slot. The read strobe is raised in the fourth clock of the slot, the byte is captured at the end of that clock, and the remaining four clocks pass idle. A byte of zero ends the channel: the completed flag is set and the do-transfer flag is cleared. After a zero byte in indirect mode, the second address byte is read only when the later_active input shows that some later channel is still running. Otherwise the indirect address is left holding the single byte it got in its upper half and zero in its lower half. Bit 7 of the count byte is kept unchanged for the transfer phase to use as a repeat flag. A one-cycle done pulse marks the end of each fetch sequence.

The controller has four states. ST_IDLE waits for line events. ST_COUNT fetches the count byte. ST_IND_FIRST and ST_IND_SECOND fetch the two indirect bytes. The transitions are: IDLE to COUNT on a line event with the low seven counter bits at zero while the channel is not completed. COUNT to IND_FIRST at slot end in indirect mode, and COUNT to IDLE at slot end otherwise. IND_FIRST to IND_SECOND at slot end when the channel is not completed or later_active is high, and IND_FIRST to IDLE at slot end otherwise. IND_SECOND to IDLE at slot end.

Top module: `hdma_table_loader`

## Requirements
- R1: After reset the loader is idle (busy=0, rd_en=0, done=0), completed=1, do_transfer=0, and line_count, table_ptr and ind_addr are all zero.
- R2: A one-cycle init pulse while idle loads table_ptr from init_ptr, clears line_count to 0, sets do_transfer=1 and clears completed, so the next line event starts a fetch.
- R3: A line event while idle with line_count[6:0] not zero decrements line_count by one and reads nothing. A line event while completed is ignored: no read, and line_count is unchanged.
- R4: A line event while idle, not completed and with line_count[6:0]==0 starts a fetch. Each table read takes an 8-clock slot. rd_en is high only in the 4th clock of the slot, with rd_addr = {bank, table_ptr}.
- R5: The count byte read becomes line_count, and table_ptr advances by one. completed is set exactly when the byte is 0, and do_transfer is its inverse.
- R6: In indirect mode the next table byte is read into ind_addr[15:8], with ind_addr[7:0] cleared, and table_ptr advances by one.
- R7: The second indirect byte is read only if the channel is not completed or later_active is high (sampled at the end of the first indirect slot). It moves the earlier byte to ind_addr[7:0], puts the new byte in ind_addr[15:8] and advances table_ptr.
- R8: done pulses for exactly one cycle when the sequence ends. From the line event that starts a fetch, it appears 8×(number of reads) clocks later. In direct mode ind_addr is unchanged.
- R9: Bit 7 of the count byte is kept in line_count. A count of 0x80 leaves the channel active with low bits zero, so the next line event triggers another fetch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| init | input | 1 | Load the table pointer and arm the channel |
| init_ptr | input | 16 | Table start pointer |
| bank | input | 8 | Table bank, upper address byte |
| indirect_mode | input | 1 | Fetch an indirect address after the count byte |
| later_active | input | 1 | Some later channel is still active |
| line_tick | input | 1 | One-cycle line event |
| rd_en | output | 1 | Table read strobe |
| rd_addr | output | 24 | Table read address {bank, pointer} |
| rd_data | input | 8 | Byte returned in the strobe cycle |
| busy | output | 1 | Fetch sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| completed | output | 1 | Channel has reached a zero count |
| do_transfer | output | 1 | Channel should transfer on this line |
| line_count | output | 8 | Line counter with repeat bit 7 |
| table_ptr | output | 16 | Table pointer |
| ind_addr | output | 16 | Indirect data address |

## Verification
The bench sweeps count bytes 0x00, 0x01, 0x05, 0x7F, 0x80, 0x81 and 0xFF across both direct and indirect mode and both levels of later_active. The zero byte separates the half-formed indirect address from the full one and shows whether later_active decides the second read. The values 0x80 and 0x81 differ only in whether the low seven bits allow an immediate reload, and 0xFF checks that the repeat bit survives a decrement. For each case the bench checks the read count, the read addresses, the latency to done, the pointer advance and the follow-up line event.

// File: rtl/hdma_ldr_pkg.sv
package hdma_ldr_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_COUNT,
        ST_IND_FIRST,
        ST_IND_SECOND
    } ldr_state_e;
endpackage

// File: rtl/hdma_slot_timer.sv
module hdma_slot_timer #(
    parameter int HALF_SLOT = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic strobe,
    output logic slot_end
);
    localparam int SLOT  = 2 * HALF_SLOT;
    localparam int CNT_W = $clog2(SLOT);

    logic [CNT_W-1:0] phase_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run || slot_end) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + CNT_W'(1);
        end
    end

    assign strobe   = run && (phase_q == CNT_W'(HALF_SLOT - 1));
    assign slot_end = run && (phase_q == CNT_W'(SLOT - 1));
endmodule

// File: rtl/hdma_ind_assemble.sv
module hdma_ind_assemble #(
    parameter int DATA_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  load_first,
    input  logic                  load_second,
    input  logic [DATA_W-1:0]     byte_in,
    output logic [2*DATA_W-1:0]   addr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr <= '0;
        end else if (load_first) begin
            addr <= {byte_in, {DATA_W{1'b0}}};
        end else if (load_second) begin
            addr <= {byte_in, addr[2*DATA_W-1:DATA_W]};
        end
    end
endmodule

// File: rtl/hdma_table_loader.sv
module hdma_table_loader
    import hdma_ldr_pkg::*;
#(
    parameter int HALF_SLOT = 4,
    parameter int BANK_W    = 8,
    parameter int PTR_W     = 16,
    parameter int DATA_W    = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      init,
    input  logic [PTR_W-1:0]          init_ptr,
    input  logic [BANK_W-1:0]         bank,
    input  logic                      indirect_mode,
    input  logic                      later_active,
    input  logic                      line_tick,
    output logic                      rd_en,
    output logic [BANK_W+PTR_W-1:0]   rd_addr,
    input  logic [DATA_W-1:0]         rd_data,
    output logic                      busy,
    output logic                      done,
    output logic                      completed,
    output logic                      do_transfer,
    output logic [DATA_W-1:0]         line_count,
    output logic [PTR_W-1:0]          table_ptr,
    output logic [2*DATA_W-1:0]       ind_addr
);
    localparam int LOW_W = DATA_W - 1;

    ldr_state_e state_q, state_d;
    logic strobe, slot_end;
    logic reload_hit;

    hdma_slot_timer #(.HALF_SLOT(HALF_SLOT)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (state_q != ST_IDLE),
        .strobe   (strobe),
        .slot_end (slot_end)
    );

    hdma_ind_assemble #(.DATA_W(DATA_W)) u_ind (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_first  (strobe && state_q == ST_IND_FIRST),
        .load_second (strobe && state_q == ST_IND_SECOND),
        .byte_in     (rd_data),
        .addr        (ind_addr)
    );

    assign reload_hit = (line_count[LOW_W-1:0] == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!init && line_tick && !completed && reload_hit)
                    state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (slot_end)
                    state_d = indirect_mode ? ST_IND_FIRST : ST_IDLE;
            end
            ST_IND_FIRST: begin
                if (slot_end)
                    state_d = (!completed || later_active) ? ST_IND_SECOND : ST_IDLE;
            end
            ST_IND_SECOND: begin
                if (slot_end)
                    state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_count  <= '0;
            table_ptr   <= '0;
            completed   <= 1'b1;
            do_transfer <= 1'b0;
            done        <= 1'b0;
        end else begin
            done <= slot_end && (state_d == ST_IDLE);
            if (state_q == ST_IDLE) begin
                if (init) begin
                    table_ptr   <= init_ptr;
                    line_count  <= '0;
                    completed   <= 1'b0;
                    do_transfer <= 1'b1;
                end else if (line_tick && !completed && !reload_hit) begin
                    line_count <= line_count - DATA_W'(1);
                end
            end else if (strobe) begin
                table_ptr <= table_ptr + PTR_W'(1);
                if (state_q == ST_COUNT) begin
                    line_count  <= rd_data;
                    completed   <= (rd_data == '0);
                    do_transfer <= (rd_data != '0);
                end
            end
        end
    end

    assign rd_en   = strobe;
    assign rd_addr = {bank, table_ptr};
    assign busy    = (state_q != ST_IDLE);
endmodule

// File: rtl/hdma_table_loader_checker.sv
module hdma_table_loader_checker #(
    parameter int PTR_W  = 16,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              line_tick,
    input logic              init,
    input logic              rd_en,
    input logic              busy,
    input logic              done,
    input logic              completed,
    input logic              do_transfer,
    input logic [DATA_W-1:0] line_count,
    input logic [PTR_W-1:0]  table_ptr
);
    // R3: no reads outside a fetch sequence
    p_idle_no_rd_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !rd_en);

    // R3: a line event on a completed channel changes nothing
    p_tick_ignored_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && completed && line_tick && !init) |=> ($stable(line_count) && !busy));

    // R5: every read advances the pointer by one
    p_ptr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (table_ptr == $past(table_ptr) + PTR_W'(1)));

    // R5: the two flags always disagree
    p_flags_r5: assert property (@(posedge clk) disable iff (!rst_n)
        completed != do_transfer);

    // R5: at the end of a sequence, completed matches a zero count
    p_done_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (completed == (line_count == '0)));

    // R8: done is a single-cycle pulse
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
endmodule

bind hdma_table_loader hdma_table_loader_checker #(
    .PTR_W(PTR_W), .DATA_W(DATA_W)
) u_checker (
    .clk(clk), .rst_n(rst_n), .line_tick(line_tick), .init(init),
    .rd_en(rd_en), .busy(busy), .done(done), .completed(completed),
    .do_transfer(do_transfer), .line_count(line_count), .table_ptr(table_ptr)
);

// File: tb/hdma_table_loader_tb_top.sv
module hdma_table_loader_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init = 1'b0;
    logic [15:0] init_ptr = '0;
    logic [7:0]  bank = 8'h7E;
    logic        indirect_mode = 1'b0;
    logic        later_active = 1'b0;
    logic        line_tick = 1'b0;
    logic        rd_en, busy, done, completed, do_transfer;
    logic [23:0] rd_addr;
    logic [7:0]  rd_data, line_count;
    logic [15:0] table_ptr, ind_addr;
    logic [7:0]  tbl [64];

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    assign rd_data = tbl[rd_addr[5:0]];

    hdma_table_loader dut_i (
        .clk(clk), .rst_n(rst_n), .init(init), .init_ptr(init_ptr), .bank(bank),
        .indirect_mode(indirect_mode), .later_active(later_active), .line_tick(line_tick),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .busy(busy), .done(done),
        .completed(completed), .do_transfer(do_transfer), .line_count(line_count),
        .table_ptr(table_ptr), .ind_addr(ind_addr)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // line event; returns number of negedges until done, reads seen, and address faults
    task automatic run_tick(output int lat, output int nrd, output int bad_addr, input logic [15:0] p0);
        lat = 0; nrd = 0; bad_addr = 0;
        line_tick = 1'b1;
        @(negedge clk);
        line_tick = 1'b0;
        lat = 1;
        while (!done && lat < 60) begin
            if (rd_en) begin
                if (rd_addr !== {bank, p0 + 16'(nrd)}) bad_addr++;
                nrd++;
            end
            @(negedge clk);
            lat++;
        end
    endtask

    initial begin
        int lat, nrd, bad;
        logic [15:0] prev_ind, exp_ind;
        logic [7:0] cvals [7];
        cvals = '{8'h00, 8'h01, 8'h05, 8'h7F, 8'h80, 8'h81, 8'hFF};
        for (int i = 0; i < 64; i++) tbl[i] = 8'(i * 7 + 3);
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 busy", busy, 0);
        check("R1 rd_en", rd_en, 0);
        check("R1 done", done, 0);
        check("R1 completed", completed, 1);
        check("R1 do_transfer", do_transfer, 0);
        check("R1 regs", {line_count, table_ptr}, 0);
        check("R1 ind", ind_addr, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R3: tick while completed after reset is ignored
        line_tick = 1'b1; @(negedge clk); line_tick = 1'b0;
        check("R3 ignored busy", busy, 0);
        check("R3 ignored count", line_count, 0);

        for (int ci = 0; ci < 7; ci++) begin
            for (int im = 0; im < 2; im++) begin
                for (int la = 0; la < 2; la++) begin
                    logic [7:0] c;
                    int exp_rd;
                    c = cvals[ci];
                    tbl[8] = c; tbl[9] = 8'h3C; tbl[10] = 8'hA5;
                    indirect_mode = im[0];
                    later_active = la[0];
                    init_ptr = 16'h0008;
                    init = 1'b1; @(negedge clk); init = 1'b0;
                    check("R2 ptr", table_ptr, 16'h0008);
                    check("R2 flags", {completed, do_transfer, line_count}, {2'b01, 8'h00});
                    prev_ind = ind_addr;
                    run_tick(lat, nrd, bad, 16'h0008);
                    exp_rd = 1 + im * (1 + ((c != 0 || la != 0) ? 1 : 0));
                    check("R4 read count", nrd, exp_rd);
                    check("R4 read address", bad, 0);
                    check("R8 latency", lat, 8 * exp_rd + 1);
                    check("R5 count", line_count, c);
                    check("R5 ptr", table_ptr, 16'h0008 + 16'(exp_rd));
                    check("R5 completed", {completed, do_transfer}, (c == 0) ? 2'b10 : 2'b01);
                    if (im == 0) exp_ind = prev_ind;
                    else if (exp_rd == 3) exp_ind = 16'hA53C;
                    else exp_ind = 16'h3C00;
                    check(im == 0 ? "R8 ind unchanged" : (exp_rd == 3 ? "R7 ind full" : "R6 ind half"),
                          ind_addr, exp_ind);
                    @(negedge clk);
                    check("R8 done one cycle", done, 0);
                    // follow-up line event
                    line_tick = 1'b1; @(negedge clk); line_tick = 1'b0;
                    if (c == 0) begin
                        check("R3 completed ignored", {busy, line_count}, 9'h000);
                    end else if (c[6:0] == 0) begin
                        check("R9 reload on 0x80", busy, 1);
                        while (!done) @(negedge clk);
                        @(negedge clk);
                    end else begin
                        check("R3 decrement", {busy, rd_en, line_count}, {2'b00, c - 8'd1});
                        if (c[7]) check("R9 repeat bit kept", line_count[7], 1);
                    end
                end
            end
        end
        finished = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!finished && cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=done", cyc);
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule